// File: doc/BRIEF.md
# Condition Field Masked Logic Unit

This block executes a family of condition-field instructions in one cycle. It holds eight 4-bit condition fields and takes a 64-bit integer operand. For each field bit, the bit is compared with a per-bit pattern bit under a per-bit enable. The results are then reduced to one bit, or merged into a destination field. The merge can keep or clear the bits that are not enabled, and one variant inverts the result with an XOR. The possible outputs are one integer result bit, a rewritten condition field, or a single condition bit.

Instructions arrive on a valid/ready issue port. An instruction is accepted on a rising edge where `in_valid` and `in_ready` are both high. The integer result leaves on a valid/ready result port. That port holds one entry. While a result is waiting and `out_ready` is low, `in_ready` is low, so every variant stalls. This is back-pressure on the issue side. Field writes take place at the accepting edge.

Top module: `cfl_unit`

## Requirements
- R1: The variant is chosen from `in_sel` and `in_rc`. The codes are: 0 = field-to-integer reduce, 1 = integer-to-field, 2 = single-bit target, 3 with `in_rc`=0 = field-to-field, 3 with `in_rc`=1 = masked move.
- R2: Field-to-integer forms terms t_i = mask_i AND (pattern_i == field bit i), where field bit i is bit i of field `in_src_fld`. It reduces the terms with OR when `in_m`=1 and with AND when `in_m`=0. From the edge after acceptance, `out_valid`=1 and `out_int` = {63 zeros, result}.
- R3: Field-to-integer with `in_rc`=1 also writes field 0. Bit 3 is less-than and is cleared. Bit 2 is greater-than and is set when the result is 1. Bit 1 is equal and is set when the result is 0. Bit 0 copies `in_so`.
- R4: Integer-to-field compares every pattern bit with the integer source bit 0. That source bit is forced to 0 when `in_ra_zero`=1. Bit i of field `in_dst[2:0]` receives the term for bit i.
- R5: Field-to-field writes the term for bit i into bit i of field `in_dst[2:0]`.
- R6: In integer-to-field, field-to-field and masked move, destination bits whose mask bit is 0 keep their old value when `in_m`=1. They are cleared when `in_m`=0.
- R7: Masked move writes ((mask AND source field) merged per R6) XOR pattern.
- R8: Single-bit target reduces as in R2. It writes only bit `in_dst[4:3]` of field `in_dst[2:0]`.
- R9: `in_ready` = NOT `out_valid` OR `out_ready`. While `out_valid`=1 and `out_ready`=0, `out_int` and `out_valid` hold.
- R10: All fields reset to 0. A field write is seen by the next accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction can be accepted |
| in_sel | input | 2 | Variant selector |
| in_rc | input | 1 | Record / variant-split bit |
| in_m | input | 1 | Reduce-OR / keep-old control |
| in_mask | input | 4 | Per-bit enable |
| in_mode | input | 4 | Per-bit pattern |
| in_src_fld | input | 3 | Source field index |
| in_dst | input | 5 | Destination: [2:0] field, [4:3] bit |
| in_ra_zero | input | 1 | Integer source index is zero |
| in_int | input | 64 | Integer source |
| in_so | input | 1 | Summary-overflow flag for field 0 |
| out_valid | output | 1 | Integer result present |
| out_ready | input | 1 | Consumer takes result |
| out_int | output | 64 | Integer result |

## Verification
The integer result is due at the first falling edge after the accepting rising edge. The bench drives each instruction on a falling edge and samples `out_int` one falling edge later. A field write is due by the next instruction. The bench reads a field back by issuing a field-to-integer compare against the expected value, with full mask and AND reduction, and looks for a 1. The stall case holds `out_ready` low for two cycles and checks the held result, then checks that the blocked instruction landed only after release.

// File: rtl/cfl_pkg.sv
`timescale 1ns/1ps
package cfl_pkg;
  typedef enum logic [2:0] {
    OP_F2I  = 3'd0,
    OP_I2F  = 3'd1,
    OP_BIT  = 3'd2,
    OP_F2F  = 3'd3,
    OP_MOVE = 3'd4
  } op_e;

  // field-0 record layout
  localparam int CR_LT = 3;
  localparam int CR_GT = 2;
  localparam int CR_EQ = 1;
  localparam int CR_SO = 0;
endpackage

// File: rtl/cfl_decode.sv
`timescale 1ns/1ps
module cfl_decode
  import cfl_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       rc,
  output op_e        op
);
  always_comb begin
    unique case (sel)
      2'd0:    op = OP_F2I;
      2'd1:    op = OP_I2F;
      2'd2:    op = OP_BIT;
      default: op = rc ? OP_MOVE : OP_F2F;
    endcase
  end
endmodule

// File: rtl/cfl_fields.sv
`timescale 1ns/1ps
module cfl_fields #(
  parameter  int NFIELD = 8,
  parameter  int FW     = 4,
  localparam int FA     = $clog2(NFIELD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FA-1:0] ra_addr,
  output logic [FW-1:0] ra_data,
  input  logic [FA-1:0] rb_addr,
  output logic [FW-1:0] rb_data,
  input  logic          we,
  input  logic [FA-1:0] waddr,
  input  logic [FW-1:0] wdata
);
  logic [FW-1:0] fld_q [NFIELD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NFIELD; i++) fld_q[i] <= '0;
    end else if (we) begin
      fld_q[waddr] <= wdata;
    end
  end

  assign ra_data = fld_q[ra_addr];
  assign rb_data = fld_q[rb_addr];

  // a write lands in the addressed field for the next instruction
  p_wr_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> fld_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/cfl_alu.sv
`timescale 1ns/1ps
module cfl_alu
  import cfl_pkg::*;
#(
  parameter  int FW = 4,
  localparam int BA = $clog2(FW)
) (
  input  op_e           op,
  input  logic          m,
  input  logic [FW-1:0] mask,
  input  logic [FW-1:0] mode,
  input  logic [FW-1:0] src_v,
  input  logic [FW-1:0] old_v,
  input  logic          lsb,
  input  logic [BA-1:0] bsel,
  input  logic          so,
  output logic          red,
  output logic [FW-1:0] wdata
);
  logic [FW-1:0] cmp, term, keep;

  for (genvar i = 0; i < FW; i++) begin : g_term
    assign cmp[i]  = (op == OP_I2F) ? lsb : src_v[i];
    assign term[i] = mask[i] & (mode[i] == cmp[i]);
  end

  assign red  = m ? (|term) : (&term);
  assign keep = m ? (old_v & ~mask) : '0;

  always_comb begin
    wdata = '0;
    unique case (op)
      OP_F2I: begin
        wdata[CR_SO] = so;
        wdata[CR_GT] = red;
        wdata[CR_EQ] = ~red;
      end
      OP_I2F, OP_F2F: wdata = term | keep;
      OP_MOVE:        wdata = ((mask & src_v) | keep) ^ mode;
      OP_BIT: begin
        wdata       = old_v;
        wdata[bsel] = red;
      end
      default:        wdata = old_v;
    endcase
  end
endmodule

// File: rtl/cfl_unit.sv
`timescale 1ns/1ps
module cfl_unit
  import cfl_pkg::*;
#(
  parameter  int XLEN   = 64,
  parameter  int NFIELD = 8,
  parameter  int FW     = 4,
  localparam int FA     = $clog2(NFIELD),
  localparam int BA     = $clog2(FW),
  localparam int TW     = FA + BA
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      in_sel,
  input  logic            in_rc,
  input  logic            in_m,
  input  logic [FW-1:0]   in_mask,
  input  logic [FW-1:0]   in_mode,
  input  logic [FA-1:0]   in_src_fld,
  input  logic [TW-1:0]   in_dst,
  input  logic            in_ra_zero,
  input  logic [XLEN-1:0] in_int,
  input  logic            in_so,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_int
);
  op_e           op;
  logic          accept, we, red, res_q, unused_hi;
  logic [FA-1:0] dfld, waddr;
  logic [BA-1:0] bsel;
  logic [FW-1:0] src_v, old_v, wdata;

  assign unused_hi = ^in_int[XLEN-1:1];

  assign dfld     = in_dst[FA-1:0];
  assign bsel     = in_dst[TW-1:FA];
  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  cfl_decode u_dec (.sel(in_sel), .rc(in_rc), .op(op));

  cfl_fields #(.NFIELD(NFIELD), .FW(FW)) u_fld (
    .clk(clk), .rst_n(rst_n),
    .ra_addr(in_src_fld), .ra_data(src_v),
    .rb_addr(dfld), .rb_data(old_v),
    .we(we), .waddr(waddr), .wdata(wdata)
  );

  cfl_alu #(.FW(FW)) u_alu (
    .op(op), .m(in_m), .mask(in_mask), .mode(in_mode),
    .src_v(src_v), .old_v(old_v), .lsb(in_int[0] & ~in_ra_zero),
    .bsel(bsel), .so(in_so), .red(red), .wdata(wdata)
  );

  assign we    = accept & ((op != OP_F2I) | in_rc);
  assign waddr = (op == OP_F2I) ? '0 : dfld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= 1'b0;
    end else if (accept && op == OP_F2I) begin
      out_valid <= 1'b1;
      res_q     <= red;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_int = {{(XLEN-1){1'b0}}, res_q};

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_int)));

  p_result_due_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_F2I) |=> out_valid);

  p_record_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_F2I && in_rc) |->
      (waddr == '0 && wdata[CR_GT] != wdata[CR_EQ] && !wdata[CR_LT]));

  p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && in_m && (op == OP_I2F || op == OP_F2F)) |->
      ((wdata ^ old_v) & ~in_mask) == '0);

  p_bit_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && op == OP_BIT) |-> ($countones(wdata ^ old_v) <= 1));
endmodule

// File: tb/cfl_unit_tb.sv
`timescale 1ns/1ps
module cfl_unit_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, in_valid, in_ready, in_rc, in_m, in_ra_zero, in_so;
  logic out_valid, out_ready;
  logic [1:0]  in_sel;
  logic [3:0]  in_mask, in_mode;
  logic [2:0]  in_src_fld;
  logic [4:0]  in_dst;
  logic [63:0] in_int, out_int;

  cfl_unit u_dut (.*);

  int total = 0, bad = 0;
  logic [3:0] model [8];
  logic exp_out, exp_bit;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model of the requirements, then one-cycle drive
  task automatic issue(input logic [1:0] sel, input logic rc, input logic m,
                       input logic [3:0] mask, input logic [3:0] mode,
                       input logic [2:0] src, input logic [4:0] dst,
                       input logic raz, input logic [63:0] iv, input logic so);
    logic [3:0] sv, ov, n, keep;
    logic lsb, r;
    sv = model[src]; ov = model[dst[2:0]];
    lsb = raz ? 1'b0 : iv[0];
    for (int i = 0; i < 4; i++)
      n[i] = mask[i] && (mode[i] == ((sel == 2'd1) ? lsb : sv[i]));
    r = m ? (n != 4'h0) : (n == 4'hF);
    keep = m ? (ov & ~mask) : 4'h0;
    exp_out = (sel == 2'd0);
    exp_bit = r;
    case (sel)
      2'd0: if (rc) model[0] = {1'b0, r, ~r, so};
      2'd1: model[dst[2:0]] = n | keep;
      2'd2: model[dst[2:0]][dst[4:3]] = r;
      default: model[dst[2:0]] = rc ? (((mask & sv) | keep) ^ mode) : (n | keep);
    endcase
    @(negedge clk);
    in_sel = sel; in_rc = rc; in_m = m; in_mask = mask; in_mode = mode;
    in_src_fld = src; in_dst = dst; in_ra_zero = raz; in_int = iv; in_so = so;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic setfld(input logic [2:0] f, input logic [3:0] v);
    issue(2'd1, 1'b0, 1'b0, 4'hF, v, 3'd0, {2'b00, f}, 1'b0, 64'h1, 1'b0);
  endtask

  task automatic check_field(input logic [2:0] f, input string req);
    logic [3:0] e;
    e = model[f];
    issue(2'd0, 1'b0, 1'b0, 4'hF, e, f, 5'd0, 1'b0, 64'h0, 1'b0);
    chk(out_valid === 1'b1 && out_int === 64'h1, req, out_int, 64'h1);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
    finish_run();
  end

  initial begin
    int k;
    logic [2:0] s, d;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_sel = '0; in_rc = 0; in_m = 0; in_mask = '0; in_mode = '0;
    in_src_fld = '0; in_dst = '0; in_ra_zero = 0; in_int = '0; in_so = 0;
    for (int f = 0; f < 8; f++) model[f] = 4'h0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R10 reset outputs",
        {62'b0, out_valid, in_ready}, 64'h1);
    rst_n = 1'b1;
    for (int f = 0; f < 8; f++) check_field(f[2:0], "R10 reset field");

    // R4 R10: every field takes every value, seen by next instruction
    for (int f = 0; f < 8; f++)
      for (int v = 0; v < 16; v++) begin
        setfld(f[2:0], v[3:0]);
        check_field(f[2:0], "R10 write visible");
      end

    // R1 R2: exhaustive field-to-integer reduce
    for (int v = 0; v < 16; v++) begin
      setfld(3'd3, v[3:0]);
      for (int mk = 0; mk < 16; mk++)
        for (int md = 0; md < 16; md++)
          for (int m = 0; m < 2; m++) begin
            issue(2'd0, 1'b0, m[0], mk[3:0], md[3:0], 3'd3, 5'd0, 1'b0,
                  {60'hABCDEF012345678, v[3:0]}, 1'b0);
            chk(out_valid === 1'b1 && out_int === {63'b0, exp_bit}, "R2 reduce",
                out_int, {63'b0, exp_bit});
          end
    end

    // R3: record into field 0
    for (int c = 0; c < 4; c++) begin
      setfld(3'd6, 4'h5);
      issue(2'd0, 1'b1, 1'b0, 4'hF, c[0] ? 4'h5 : 4'h4, 3'd6, 5'd0, 1'b0, 64'h0, c[1]);
      chk(out_int === {63'b0, exp_bit}, "R3 result", out_int, {63'b0, exp_bit});
      check_field(3'd0, "R3 field0 record");
    end

    // R4 R6: integer-to-field incl. zero source index
    k = 0;
    for (int o = 0; o < 2; o++)
      for (int mk = 0; mk < 16; mk++)
        for (int md = 0; md < 16; md++)
          for (int m = 0; m < 2; m++)
            for (int sc = 0; sc < 3; sc++) begin
              d = 3'(k % 7 + 1); k++;
              setfld(d, o[0] ? 4'h9 : 4'h6);
              issue(2'd1, 1'b0, m[0], mk[3:0], md[3:0], 3'd0, {2'b11, d},
                    sc == 2, (sc == 0) ? 64'hFFFF_FFFF_FFFF_FFFE : 64'h1, 1'b0);
              check_field(d, m[0] ? "R6 keep int-to-field" : "R4 int-to-field");
            end

    // R5 R6 R7 R8: field-to-field, masked move, single-bit
    for (int sel = 0; sel < 3; sel++) begin
      k = 0;
      for (int rep = 0; rep < 4; rep++)
        for (int mk = 0; mk < 16; mk++)
          for (int md = 0; md < 16; md++)
            for (int m = 0; m < 2; m++) begin
              s = 3'(k % 8);
              d = 3'((k + 1 + (md % 7)) % 8);
              setfld(s, 4'((k * 7 + rep) % 16));
              setfld(d, 4'((k * 5 + 3) % 16));
              if (sel == 0)
                issue(2'd3, 1'b0, m[0], mk[3:0], md[3:0], s, {2'b10, d}, 1'b0, 64'h0, 1'b0);
              else if (sel == 1)
                issue(2'd3, 1'b1, m[0], mk[3:0], md[3:0], s, {2'b01, d}, 1'b0, 64'h0, 1'b0);
              else
                issue(2'd2, 1'b0, m[0], mk[3:0], md[3:0], s, {2'(k / 8), d}, 1'b0, 64'h0, 1'b0);
              check_field(d, (sel == 0) ? "R5 field-to-field" :
                             (sel == 1) ? "R7 masked move" : "R8 single bit");
              if (sel == 2) check_field(s, "R8 other field untouched");
              k++;
            end
    end

    // R9: back-pressure
    setfld(3'd5, 4'h0);
    setfld(3'd2, 4'hC);
    out_ready = 1'b0;
    issue(2'd0, 1'b0, 1'b1, 4'h8, 4'hF, 3'd2, 5'd0, 1'b0, 64'h0, 1'b0);
    chk(out_valid === 1'b1 && out_int === 64'h1 && in_ready === 1'b0, "R9 stall",
        out_int, 64'h1);
    in_sel = 2'd1; in_rc = 0; in_m = 0; in_mask = 4'hF; in_mode = 4'hF;
    in_dst = 5'd5; in_ra_zero = 0; in_int = 64'h1; in_valid = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid === 1'b1 && out_int === 64'h1 && in_ready === 1'b0, "R9 hold",
        out_int, 64'h1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model[5] = 4'hF;
    chk(out_valid === 1'b0, "R9 drained", {63'b0, out_valid}, 64'h0);
    check_field(3'd5, "R9 blocked op landed once");

    finish_run();
  end
endmodule